// File: doc/BRIEF.md
# DMA Channel Control Register

This block is the control register of one DMA channel, reached over a simple single-register read/write strobe interface. It holds four live fields, and presents their current values to the channel datapath as separate outputs:

- an ownership flag, which claims itself when it is read;
- an enable that steers completion writes toward a target processor;
- a descriptor no-snoop flag;
- an error-interrupt enable.

Software claims the channel by reading the register. The first read after the ownership flag was cleared returns 0 and sets the flag in the same access. Every later read returns 1, until the owner releases the channel by writing 0 to that bit. Writes to the fields take effect only while the channel-count input equals one. For any other count, the fields are read-only, but reads still claim the channel.

The block also produces a level error-interrupt request. It builds the request from an error-event input, a flag saying whether the error belongs to this channel, the interrupt-enable field and an abort-on-any-error input.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset every field, `rdata_o`, `rvalid_o` and `err_irq_o` are 0.
- R2: A read accepted at a clock edge gives `rvalid_o` high and `rdata_o` valid for the following cycle only. Register bits 15:10 and 7:6 always read 0. The field positions are: bit 9 steer, bit 8 in-use, bit 5 no-snoop, bit 4 error-interrupt enable.
- R3: A read while in-use is 0 returns bit 8 as 0, and in-use is 1 from the next cycle.
- R4: While in-use is 1, every read returns bit 8 as 1.
- R5: With writes permitted, writing 0 to bit 8 clears in-use. Writing 1 to bit 8 never changes in-use.
- R6: With writes permitted, bits 9, 5 and 4 take the written values. The change appears on the field outputs and in read data from the next cycle.
- R7: When `chan_cnt_i` is not 1, writes change no field, including in-use, while a read still claims the channel.
- R8: When a read and a write are accepted together, the read returns the value held before both accesses. The claim is applied first and the write second.
- R9: `err_irq_o` rises one cycle after `err_evt_i` is high with either (`err_affil_i` and bit 4 set) or `abort_en_i` set.
- R10: Once raised, `err_irq_o` stays high while `err_evt_i` stays high, whatever the enables do. It falls one cycle after `err_evt_i` goes low.
- R11: An error with `err_affil_i` low raises no request while `abort_en_i` is low, even with bit 4 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Read request, accepted at the clock edge |
| wr_en_i | input | 1 | Write request, accepted at the clock edge |
| wdata_i | input | 16 | Write data |
| chan_cnt_i | input | 8 | Channel count; writes are permitted only when it is 1 |
| err_evt_i | input | 1 | Error event level |
| err_affil_i | input | 1 | The error belongs to this channel |
| abort_en_i | input | 1 | Abort on any error enable |
| rdata_o | output | 16 | Read data |
| rvalid_o | output | 1 | Read data valid |
| steer_en_o | output | 1 | Completion-write steering enable |
| in_use_o | output | 1 | Channel ownership flag |
| desc_nosnoop_o | output | 1 | Descriptors are non-coherent |
| err_irq_en_o | output | 1 | Error interrupt enable |
| err_irq_o | output | 1 | Error interrupt request |

## Verification
Some properties are checked by assertions on every cycle:

- the read-valid pulse and the zeroed reserved bits;
- that in-use never rises without a read;
- that a permitted release always clears in-use;
- that fields stay stable under a locked write;
- the hold, drop and unaffiliated-error rules of the interrupt level.

The directed scenarios are needed for the full sequence of claiming reads. They also cover the exact value returned by simultaneous read and write, lock behaviour at several channel counts, and which enable combinations raise the interrupt.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  localparam int REG_W     = 16;
  localparam int BIT_STEER = 9;
  localparam int BIT_INUSE = 8;
  localparam int BIT_NOSNP = 5;
  localparam int BIT_IRQEN = 4;
  localparam int NUM_LCK   = 3;

  function automatic logic [REG_W-1:0] pack_reg(logic steer, logic inuse,
                                                logic nosnp, logic irqen);
    logic [REG_W-1:0] r;
    r = '0;
    r[BIT_STEER] = steer;
    r[BIT_INUSE] = inuse;
    r[BIT_NOSNP] = nosnp;
    r[BIT_IRQEN] = irqen;
    return r;
  endfunction
endpackage

// File: rtl/dma_cc_claim.sv
module dma_cc_claim (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_en_i,
  input  logic rel_i,
  output logic in_use_o
);
  logic in_use_q;

  // claim first, then release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      in_use_q <= 1'b0;
    else if (rel_i)   in_use_q <= 1'b0;
    else if (rd_en_i) in_use_q <= 1'b1;
  end

  assign in_use_o = in_use_q;

  p_no_self_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !$rose(in_use_o));
  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_i |=> !in_use_o);
endmodule

// File: rtl/dma_cc_fields.sv
module dma_cc_fields #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   b_q <= 1'b0;
      else if (wr_i) b_q <= d_i[i];
    end
    assign q_o[i] = b_q;
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(q_o));
endmodule

// File: rtl/dma_cc_irq.sv
module dma_cc_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic affil_i,
  input  logic en_i,
  input  logic abort_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= evt_i & (irq_q | (en_i & affil_i) | abort_i);
  end

  assign irq_o = irq_q;

  p_irq_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> !irq_o);
  p_irq_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && evt_i) |=> irq_o);
  p_irq_unaff_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !affil_i && !abort_i) |=> !irq_o);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dma_cc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] chan_cnt_i,
  input  logic             err_evt_i,
  input  logic             err_affil_i,
  input  logic             abort_en_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             rvalid_o,
  output logic             steer_en_o,
  output logic             in_use_o,
  output logic             desc_nosnoop_o,
  output logic             err_irq_en_o,
  output logic             err_irq_o
);
  logic               wr_ok;
  logic               rel;
  logic [NUM_LCK-1:0] fld_d, fld_q;
  logic [REG_W-1:0]   rdata_q;
  logic               rvalid_q;
  logic               unused_wdata;

  assign wr_ok = wr_en_i && (chan_cnt_i == CNT_W'(1));
  assign rel   = wr_ok && !wdata_i[BIT_INUSE];
  assign fld_d = {wdata_i[BIT_STEER], wdata_i[BIT_NOSNP], wdata_i[BIT_IRQEN]};
  assign unused_wdata = ^{wdata_i[15:10], wdata_i[7:6], wdata_i[3:0]};

  dma_cc_claim u_claim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .rel_i   (rel),
    .in_use_o(in_use_o)
  );

  dma_cc_fields #(.N(NUM_LCK)) u_fields (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (wr_ok),
    .d_i   (fld_d),
    .q_o   (fld_q)
  );

  assign {steer_en_o, desc_nosnoop_o, err_irq_en_o} = fld_q;

  dma_cc_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (err_evt_i),
    .affil_i(err_affil_i),
    .en_i   (err_irq_en_o),
    .abort_i(abort_en_i),
    .irq_o  (err_irq_o)
  );

  // read returns pre-access value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en_i;
      if (rd_en_i)
        rdata_q <= pack_reg(steer_en_o, in_use_o, desc_nosnoop_o, err_irq_en_o);
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  p_rvalid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  p_rvalid_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  p_rsv_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o[15:10] == '0 && rdata_o[7:6] == '0));
  p_read_old_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rdata_o[BIT_INUSE] == $past(in_use_o));
  p_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && chan_cnt_i != CNT_W'(1) && !rd_en_i) |=>
      $stable({steer_en_o, in_use_o, desc_nosnoop_o, err_irq_en_o}));
endmodule

// File: tb/dma_chan_ctl_tb_top.sv
module dma_chan_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [7:0]  chan_cnt = 8'd1;
  logic        err_evt = 1'b0, err_affil = 1'b0, abort_en = 1'b0;
  logic [15:0] rdata;
  logic        rvalid, steer, in_use, nosnp, irq_en, irq;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  dma_chan_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .wdata_i(wdata), .chan_cnt_i(chan_cnt), .err_evt_i(err_evt),
    .err_affil_i(err_affil), .abort_en_i(abort_en), .rdata_o(rdata),
    .rvalid_o(rvalid), .steer_en_o(steer), .in_use_o(in_use),
    .desc_nosnoop_o(nosnp), .err_irq_en_o(irq_en), .err_irq_o(irq)
  );

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic acc(logic rd, logic wr, logic [15:0] d);
    @(negedge clk);
    rd_en = rd; wr_en = wr; wdata = d;
    @(posedge clk); #1;
    rd_en = 1'b0; wr_en = 1'b0;
  endtask

  function automatic logic [15:0] fields();
    return {6'b0, steer, in_use, 2'b0, nosnp, irq_en, 4'b0};
  endfunction

  task automatic t_reset();
    chk("R1 fields", fields(), 16'h0000);
    chk("R1 rdata", rdata, 16'h0000);
    chk("R1 rvalid", 16'(rvalid), 16'h0);
    chk("R1 irq", 16'(irq), 16'h0);
  endtask

  task automatic t_claim();
    chan_cnt = 8'd1;
    acc(1, 0, '0);
    chk("R3 first read", rdata, 16'h0000);
    chk("R2 rvalid", 16'(rvalid), 16'h1);
    chk("R3 claimed", 16'(in_use), 16'h1);
    acc(1, 0, '0);
    chk("R4 second read", rdata, 16'h0100);
    acc(0, 0, '0);
    chk("R2 rvalid drops", 16'(rvalid), 16'h0);
  endtask

  task automatic t_fields();
    acc(0, 1, 16'hFFFF);
    chk("R6 fields set", fields(), 16'h0330);
    acc(1, 0, '0);
    chk("R2 rsv zero readback", rdata, 16'h0330);
    acc(0, 1, 16'h0000);
    chk("R5 release", fields(), 16'h0000);
    acc(0, 1, 16'h0100);
    chk("R5 write one no claim", 16'(in_use), 16'h0);
  endtask

  task automatic t_lock();
    chan_cnt = 8'd2;
    acc(0, 1, 16'h0230);
    chk("R7 locked cnt2", fields(), 16'h0000);
    acc(1, 0, '0);
    chk("R7 claim when locked", 16'(in_use), 16'h1);
    chan_cnt = 8'd0;
    acc(0, 1, 16'h0000);
    chk("R7 no release cnt0", 16'(in_use), 16'h1);
    chan_cnt = 8'd1;
    acc(0, 1, 16'h0000);
    chk("R5 release again", 16'(in_use), 16'h0);
  endtask

  task automatic t_same();
    acc(1, 1, 16'h0000);
    chk("R8 rd+wr0 data", rdata, 16'h0000);
    chk("R8 rd+wr0 in_use", 16'(in_use), 16'h0);
    acc(1, 1, 16'h0110);
    chk("R8 rd+wr1 data", rdata, 16'h0000);
    chk("R8 rd+wr1 state", fields(), 16'h0110);
    acc(1, 1, 16'h0000);
    chk("R8 old value", rdata, 16'h0110);
    chk("R8 then release", fields(), 16'h0000);
  endtask

  task automatic t_irq();
    acc(0, 1, 16'h0010);
    @(negedge clk); err_evt = 1; err_affil = 1;
    @(posedge clk); #1;
    chk("R9 affil irq", 16'(irq), 16'h1);
    acc(0, 1, 16'h0000);
    chk("R10 hold", 16'(irq), 16'h1);
    @(negedge clk); err_evt = 0;
    @(posedge clk); #1;
    chk("R10 drop", 16'(irq), 16'h0);
    acc(0, 1, 16'h0010);
    @(negedge clk); err_evt = 1; err_affil = 0;
    @(posedge clk); #1;
    chk("R11 unaffil", 16'(irq), 16'h0);
    @(negedge clk); abort_en = 1;
    @(posedge clk); #1;
    chk("R9 abort irq", 16'(irq), 16'h1);
    @(negedge clk); err_evt = 0; abort_en = 0;
    @(posedge clk); #1;
    chk("R10 drop abort", 16'(irq), 16'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_ni = 1'b1;
    t_claim();
    t_fields();
    t_lock();
    t_same();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule